// File: doc/BRIEF.md
# Three-Wire Configuration Register Port

This block is the configuration slave of a pager receiver's frequency synthesiser. A host controller drives a serial clock, a serial data line and a latch-enable line. While latch enable is low, each rising edge of the serial clock shifts one data bit into the block. A command is 17 bits long: a 16-bit payload sent most significant bit first, then one address bit. When latch enable then rises, the block copies the payload into the register that the address bit selects.

Address 0 selects the 16-bit synthesiser divide ratio. Address 1 selects the set-up word. The set-up word carries a five-bit reference-divider selection and a demodulator-only mode flag. The remaining ten bits of the set-up word are reserved.

All three serial lines are asynchronous to the system clock. Each passes through a two-flop synchroniser and is sampled in the system clock domain, so the serial clock must stay well below the system clock rate. The serial clock may stop between commands. The registers keep their contents until reset.

Each accepted load raises a one-cycle strobe for its register. Downstream logic uses the strobe to restart what depends on the value, such as reloading the programmable divider. A latch with the wrong number of bits changes no register and raises a one-cycle error strobe instead.

Top module: `serial_cfg_port`

## Requirements
- R1: During and after reset, `div_ratio_o`, `ref_div_sel_o` and `demod_only_o` are zero, and `ratio_load_o`, `setup_load_o` and `frame_err_o` are low.
- R2: A command of exactly 17 bits whose last bit is 0 loads the 16 bits sent before it into `div_ratio_o`. The first bit sent is bit 15 and the sixteenth is bit 0.
- R3: A command of exactly 17 bits whose last bit is 1 updates the set-up fields. Payload bit 5 goes to `demod_only_o`. Payload bits 4 down to 0 go to `ref_div_sel_o[4:0]`, so bit 0 is the least significant selection bit. `div_ratio_o` is left unchanged.
- R4: Payload bits 15 down to 6 of a set-up command are reserved. A nonzero value there has no effect, and the command is still accepted.
- R5: If the number of bits shifted since the previous latch is not exactly 17 when latch enable rises, no register changes and `frame_err_o` pulses for one cycle. The counts covered include 0, 16 and 18.
- R6: Exactly one of `ratio_load_o`, `setup_load_o` or `frame_err_o` pulses high for one system cycle per latch-enable rise. The pulse comes 3 system clock edges after latch enable rises, and it appears in the same cycle as the new register value.
- R7: Register outputs change only together with their load strobe. They hold while the serial clock is idle, while the data line toggles, and while the other register is written.
- R8: Serial clock edges that occur while latch enable is high shift nothing and are not counted. Every latch restarts the bit count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial bit clock; data is sampled on its rising edge |
| ser_dat_i | input | 1 | Serial data, payload MSB first, then the address bit |
| ser_le_i | input | 1 | Latch enable; its rising edge commits the shifted command |
| div_ratio_o | output | 16 | Synthesiser divide ratio register |
| ref_div_sel_o | output | 5 | Reference-divider selection bits from the set-up word |
| demod_only_o | output | 1 | Demodulator-only mode flag from the set-up word |
| ratio_load_o | output | 1 | One-cycle strobe when the divide ratio is loaded |
| setup_load_o | output | 1 | One-cycle strobe when the set-up word is loaded |
| frame_err_o | output | 1 | One-cycle strobe when a latch has the wrong bit count |

## Verification
Every result of this block appears 3 system clock edges after latch enable rises. Two of those edges are the synchroniser and one is the register update. The bench drives latch enable half a cycle after a rising edge and records the cycle counter at that moment. It then pushes an expected item whose due cycle is that count plus three. The monitor samples on falling edges and pops an item only when a strobe is high. It compares the strobe kind, the register values and the current cycle with the due cycle. A strobe that nobody expected, or one that lasts two cycles, shows up as a pop from an empty queue.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;

  // Payload width of one command (the address bit follows it).
  localparam int CFG_PAYLOAD_W = 16;
  // Set-up word field layout, decoded by the downstream divider and demodulator.
  localparam int SETUP_SEL_W   = 5;
  localparam int SETUP_SEL_LSB = 0;
  localparam int SETUP_DMO_POS = 5;

  typedef struct packed {
    logic                   dmo;
    logic [SETUP_SEL_W-1:0] sel;
  } setup_t;

  // The address bit is the last one shifted, so it sits at bit 0 of the frame.
  function automatic logic frame_is_setup(input logic [CFG_PAYLOAD_W:0] frame);
    return frame[0];
  endfunction

  function automatic logic [CFG_PAYLOAD_W-1:0] frame_payload(input logic [CFG_PAYLOAD_W:0] frame);
    return frame[CFG_PAYLOAD_W:1];
  endfunction

  // Reserved bits above the mode flag are dropped here.
  function automatic setup_t decode_setup(input logic [CFG_PAYLOAD_W-1:0] payload);
    setup_t s;
    s.dmo = payload[SETUP_DMO_POS];
    s.sel = payload[SETUP_SEL_LSB +: SETUP_SEL_W];
    return s;
  endfunction

endpackage

// File: rtl/cfgbus_sync.sv
module cfgbus_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/cfgbus_shifter.sv
module cfgbus_shifter #(
  parameter int FRAME_LEN = 17,
  parameter int CNT_W     = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk_s,
  input  logic                 sdat_s,
  input  logic                 le_s,
  output logic [FRAME_LEN-1:0] frame_o,
  output logic                 latch_rise_o,
  output logic                 frame_ok_o
);

  localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_FRAME = CNT_W'(FRAME_LEN);

  logic                 sclk_q, le_q;
  logic                 shift_ev;
  logic [CNT_W-1:0]     cnt_q;
  logic [FRAME_LEN-1:0] shift_q;

  // Edges are found in the system domain; clocks during latch are ignored.
  assign shift_ev     = sclk_s & ~sclk_q & ~le_s;
  assign latch_rise_o = le_s & ~le_q;
  assign frame_ok_o   = (cnt_q == CNT_FRAME);
  assign frame_o      = shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      le_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      le_q   <= le_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      shift_q <= '0;
    end else if (latch_rise_o) begin
      cnt_q   <= '0;
    end else if (shift_ev) begin
      shift_q <= {shift_q[FRAME_LEN-2:0], sdat_s};
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R8: every latch restarts the count.
  p_cnt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    latch_rise_o |=> (cnt_q == '0));

  // R8: nothing shifts while latch enable stays high.
  p_hold_latched_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (le_s && le_q) |=> ($stable(shift_q) && $stable(cnt_q)));

endmodule

// File: rtl/cfgbus_regfile.sv
module cfgbus_regfile
  import cfgbus_pkg::*;
#(
  parameter int PAYLOAD_W = CFG_PAYLOAD_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PAYLOAD_W:0]   frame_i,
  input  logic                 latch_rise_i,
  input  logic                 frame_ok_i,
  output logic [PAYLOAD_W-1:0] ratio_o,
  output setup_t               setup_o,
  output logic                 ratio_ld_o,
  output logic                 setup_ld_o,
  output logic                 err_o
);

  logic accept, to_setup;

  assign accept   = latch_rise_i & frame_ok_i;
  assign to_setup = frame_is_setup(frame_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_o    <= '0;
      setup_o    <= '0;
      ratio_ld_o <= 1'b0;
      setup_ld_o <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      ratio_ld_o <= accept & ~to_setup;
      setup_ld_o <= accept &  to_setup;
      err_o      <= latch_rise_i & ~frame_ok_i;
      if (accept && !to_setup) ratio_o <= frame_payload(frame_i);
      if (accept &&  to_setup) setup_o <= decode_setup(frame_payload(frame_i));
    end
  end

  // R5: a rejected frame never loads.
  p_err_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!ratio_ld_o && !setup_ld_o));

  // R6: strobes last one cycle.
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_ld_o || setup_ld_o || err_o) |=> !(ratio_ld_o || setup_ld_o || err_o));

  // R7: register values move only with their own strobe.
  p_ratio_on_ld_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ratio_o) |-> ratio_ld_o);
  p_setup_on_ld_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(setup_o) |-> setup_ld_o);

endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import cfgbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ser_clk_i,
  input  logic                     ser_dat_i,
  input  logic                     ser_le_i,
  output logic [CFG_PAYLOAD_W-1:0] div_ratio_o,
  output logic [SETUP_SEL_W-1:0]   ref_div_sel_o,
  output logic                     demod_only_o,
  output logic                     ratio_load_o,
  output logic                     setup_load_o,
  output logic                     frame_err_o
);

  localparam int FRAME_LEN = CFG_PAYLOAD_W + 1;

  logic [2:0]           raw_in, sync_out;
  logic [FRAME_LEN-1:0] frame;
  logic                 latch_rise, frame_ok;
  setup_t               setup;

  assign raw_in = {ser_le_i, ser_dat_i, ser_clk_i};

  cfgbus_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_in),
    .q_o   (sync_out)
  );

  cfgbus_shifter #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .sclk_s       (sync_out[0]),
    .sdat_s       (sync_out[1]),
    .le_s         (sync_out[2]),
    .frame_o      (frame),
    .latch_rise_o (latch_rise),
    .frame_ok_o   (frame_ok)
  );

  cfgbus_regfile #(.PAYLOAD_W(CFG_PAYLOAD_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_i      (frame),
    .latch_rise_i (latch_rise),
    .frame_ok_i   (frame_ok),
    .ratio_o      (div_ratio_o),
    .setup_o      (setup),
    .ratio_ld_o   (ratio_load_o),
    .setup_ld_o   (setup_load_o),
    .err_o        (frame_err_o)
  );

  assign ref_div_sel_o = setup.sel;
  assign demod_only_o  = setup.dmo;

  // R6: every strobe answers a latch rise seen one edge earlier.
  p_ld_after_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_load_o || setup_load_o || frame_err_o) |-> $past(latch_rise));

  // R1: nothing is strobed while in reset.
  always_comb begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!ratio_load_o && !setup_load_o && !frame_err_o);
    end
  end

endmodule

// File: tb/serial_cfg_port_tb.sv
module serial_cfg_port_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, sdat = 1'b0, sle = 1'b0;
  logic [15:0] ratio;
  logic [4:0]  rsel;
  logic        dmo, r_ld, s_ld, f_err;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  // Reference model of the register contents.
  logic [15:0] m_ratio = '0;
  logic [4:0]  m_sel   = '0;
  logic        m_dmo   = 1'b0;

  typedef struct {
    int          kind;   // 0 ratio, 1 setup, 2 error
    logic [15:0] ratio;
    logic [4:0]  sel;
    logic        dmo;
    int          due;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  serial_cfg_port dut_i (
    .clk(clk), .rst_n(rst_n),
    .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_le_i(sle),
    .div_ratio_o(ratio), .ref_div_sel_o(rsel), .demod_only_o(dmo),
    .ratio_load_o(r_ld), .setup_load_o(s_ld), .frame_err_o(f_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    chk(ratio == m_ratio, req, "div_ratio", ratio, m_ratio);
    chk(rsel == m_sel,    req, "ref_div_sel", rsel, m_sel);
    chk(dmo == m_dmo,     req, "demod_only", dmo, m_dmo);
  endtask

  // Monitor: pops one expected item per strobe, at the falling edge.
  always @(negedge clk) begin
    if (rst_n && (r_ld || s_ld || f_err)) begin
      int kind_act;
      item_t it;
      kind_act = r_ld ? 0 : (s_ld ? 1 : 2);
      if (sb_q.size() == 0) begin
        chk(1'b0, "R6", "unexpected strobe kind", kind_act, 3);
      end else begin
        it = sb_q.pop_front();
        chk($countones({r_ld, s_ld, f_err}) == 1, "R6", "strobe count",
            $countones({r_ld, s_ld, f_err}), 1);
        chk(kind_act == it.kind, "R6", "strobe kind", kind_act, it.kind);
        chk(cyc == it.due, "R6", "strobe cycle", cyc, it.due);
        if (it.kind == 0) chk(ratio == it.ratio, "R2", "loaded ratio", ratio, it.ratio);
        if (it.kind == 1) begin
          chk(rsel == it.sel, "R3", "loaded selection", rsel, it.sel);
          chk(dmo == it.dmo,  "R3", "loaded mode flag", dmo, it.dmo);
        end
      end
    end
  end

  task automatic send_bit(input logic b);
    @(negedge clk); sdat = b;
    repeat (3) @(negedge clk); sclk = 1'b1;
    repeat (4) @(negedge clk); sclk = 1'b0;
  endtask

  task automatic send_stream(input logic [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(bits[i]);
  endtask

  // Raise latch enable, predict the result, then lower it.
  task automatic latch(input int kind);
    item_t it;
    repeat (2) @(negedge clk);
    sle = 1'b1;
    it.kind = kind; it.ratio = m_ratio; it.sel = m_sel; it.dmo = m_dmo;
    it.due = cyc + 3;
    sb_q.push_back(it);
    repeat (6) @(negedge clk);
    sle = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic write_ratio(input logic [15:0] v);
    send_stream({15'd0, v, 1'b0}, 17);
    m_ratio = v;
    latch(0);
  endtask

  task automatic write_setup(input logic [15:0] v);
    send_stream({15'd0, v, 1'b1}, 17);
    m_sel = v[4:0];
    m_dmo = v[5];
    latch(1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state, while held and after release.
    check_regs("R1");
    chk(!r_ld && !s_ld && !f_err, "R1", "strobes in reset", {r_ld, s_ld, f_err}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_regs("R1");

    // R2: divide ratio, MSB first.
    write_ratio(16'hA5C3);
    check_regs("R2");
    // R3: set-up word; ratio untouched (R7).
    write_setup(16'h002D);
    check_regs("R3");
    chk(ratio == 16'hA5C3, "R7", "ratio kept across setup write", ratio, 16'hA5C3);
    // R4: reserved bits set, still accepted.
    write_setup(16'hFFD2);
    check_regs("R4");
    chk(rsel == 5'h12 && dmo == 1'b0, "R4", "reserved ignored", {dmo, rsel}, 6'h12);

    // R5: wrong bit counts.
    send_stream(32'h0000_FFFF, 16);
    latch(2);
    check_regs("R5");
    send_stream(32'h0003_FFFF, 18);
    latch(2);
    check_regs("R5");
    latch(2);  // zero bits since last latch
    check_regs("R5");

    // R8: clocks while latched do not count; frame after is clean.
    @(negedge clk); sle = 1'b1;
    begin
      item_t it;
      it.kind = 2; it.ratio = m_ratio; it.sel = m_sel; it.dmo = m_dmo;
      it.due = cyc + 3;
      sb_q.push_back(it);
    end
    send_stream(32'h0000_0015, 5);
    @(negedge clk); sle = 1'b0;
    repeat (6) @(negedge clk);
    write_ratio(16'h1234);
    check_regs("R8");

    // R7: data toggling with serial clock idle changes nothing.
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); sdat = ~sdat;
      repeat (2) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    check_regs("R7");

    // R2/R3 boundary values.
    write_ratio(16'hFFFF);
    check_regs("R2");
    write_ratio(16'h0000);
    check_regs("R2");
    write_setup(16'h003F);
    check_regs("R3");
    write_setup(16'h0000);
    check_regs("R3");

    repeat (20) @(negedge clk);
    chk(sb_q.size() == 0, "R6", "missing strobes", sb_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule